// File: doc/BRIEF.md
# Display Link Lane Budget Checker

This block decides how many lanes of a shared serial display link a pipe may use. A request gives the pipe index, the pixel clock in kHz, the link symbol rate, the starting colour depth in bits per pixel, the platform mode, and the state of the one other pipe that competes for lanes. Each lane carries 8 data bits per 10 line bits, so the useful payload per lane is the link rate times 8. The block divides pixel clock times bpp by that figure with a sequential divider and rounds up.

The lane count is then judged against the sharing rules. On a three-pipe platform, pipes B and C split one group of lanes. If the request breaks a rule and the colour depth is still above 18 bpp, the block lowers the depth by 6 bpp, divides again and judges again. It stops when the request fits or the depth can go no lower. The outcome is reported with a one-cycle `done` strobe. The result is held on the outputs until the next request starts.

Top module: `lane_budget_top`

## Requirements
- R1: The reported lane count is ceil(pix_khz × bpp_out / (link_rate × 8)), saturated at 2^LANE_W − 1 (15 by default).
- R2: A lane count above 4 is rejected in every mode and for every pipe.
- R3: When `plat_mode[1]` is 1 (codes 2 and 3, the two-lane platform), a count above 2 is rejected and any other count is accepted.
- R4: In mode 0 (two-pipe platform), any count up to 4 is accepted. In mode 1 (three-pipe platform), pipe code 0 (A) and the spare pipe code 3 are also accepted up to 4.
- R5: In mode 1, pipe code 1 (B) is accepted up to 2 lanes. Above 2 lanes it is accepted only if the peer need is zero.
- R6: In mode 1, pipe code 2 (C) is rejected above 2 lanes. It is also rejected when the peer need exceeds 2.
- R7: The peer need equals `peer_lanes` only when both `peer_en` and `peer_ext` are 1. Otherwise it is zero.
- R8: On a rejection with bpp above 18, bpp drops by 6, the lanes are recomputed and checked again, and `constrained` is set. `bpp_out` reports the final depth.
- R9: A rejection at bpp of 18 or below ends the request with `fail` = 1 and `ok` = 0.
- R10: `done` is high for exactly one cycle per request. During `done`, exactly one of `ok` and `fail` is high, and all results hold until the next accepted start.
- R11: A `start` pulse while a request is in progress is ignored and has no effect on the result.
- R12: After reset, `done`, `ok`, `fail`, `constrained`, `lanes` and `bpp_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| pipe_sel | input | 2 | Pipe: 0 A, 1 B, 2 C, 3 spare (treated as A) |
| plat_mode | input | 2 | 0 two-pipe, 1 three-pipe, 2/3 two-lane |
| pix_khz | input | PCLK_W | Pixel clock in kHz |
| link_rate | input | LR_W | Link symbol rate, same unit as the pixel clock |
| bpp_in | input | BPP_W | Starting bits per pixel |
| peer_en | input | 1 | Competing pipe is enabled |
| peer_ext | input | 1 | Competing pipe drives the external link |
| peer_lanes | input | LANE_W | Lanes the competing pipe uses |
| done | output | 1 | One-cycle completion strobe |
| lanes | output | LANE_W | Final lane count |
| bpp_out | output | BPP_W | Final bits per pixel |
| ok | output | 1 | Request accepted |
| fail | output | 1 | Request rejected at the depth floor |
| constrained | output | 1 | Depth was lowered at least once |

## Verification
The bench sweeps every pipe code and every platform mode. Each is crossed with peer states that separate the enable and external-drive gates and with peer lane counts on both sides of the 0 and 2 thresholds. Pixel clocks are chosen to land the count at 0, 1, 2, 3, 4 and beyond 4 lanes, at starting depths of 24 and 36 bpp. This splits the B rule from the C rule, and a real peer need from one that the gate zeroes. Directed cases start at 20 and at 18 bpp to tell a reduction below the floor apart from an immediate failure. A second start injected mid-run shows whether the latched request is kept.

// File: rtl/lane_budget_pkg.sv
package lane_budget_pkg;

   typedef enum logic [1:0] {
      PIPE_A     = 2'd0,
      PIPE_B     = 2'd1,
      PIPE_C     = 2'd2,
      PIPE_SPARE = 2'd3
   } pipe_id_e;

   typedef enum logic [1:0] {
      MODE_DUAL   = 2'd0,
      MODE_TRI    = 2'd1,
      MODE_NARROW = 2'd2,
      MODE_NARR2  = 2'd3
   } plat_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_KICK = 2'd1,
      ST_WAIT = 2'd2,
      ST_EVAL = 2'd3
   } fsm_e;

endpackage

// File: rtl/lane_div.sv
// Restoring divider, one quotient bit per cycle, NW cycles per division.
module lane_div #(
   parameter int NW = 26,
   parameter int DW = 23
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          fin,
   output logic [NW-1:0] quot,
   output logic [DW-1:0] rem
);
   localparam int CW = $clog2(NW) + 1;
   localparam logic [CW-1:0] LAST = CW'(NW - 1);

   logic [NW-1:0] q_r;
   logic [DW-1:0] r_r;
   logic [DW-1:0] d_r;
   logic [CW-1:0] cnt_r;
   logic          run_r;
   logic [DW:0]   trial;
   logic          fits;

   always_comb begin
      trial = {r_r, q_r[NW-1]};
      fits  = (trial >= {1'b0, d_r});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r   <= '0;
         r_r   <= '0;
         d_r   <= '0;
         cnt_r <= '0;
         run_r <= 1'b0;
         fin   <= 1'b0;
      end else if (go) begin
         q_r   <= num;
         r_r   <= '0;
         d_r   <= den;
         cnt_r <= '0;
         run_r <= 1'b1;
         fin   <= 1'b0;
      end else if (run_r) begin
         if (fits) begin
            r_r <= DW'(trial - {1'b0, d_r});
            q_r <= {q_r[NW-2:0], 1'b1};
         end else begin
            r_r <= trial[DW-1:0];
            q_r <= {q_r[NW-2:0], 1'b0};
         end
         cnt_r <= cnt_r + 1'b1;
         if (cnt_r == LAST) begin
            run_r <= 1'b0;
            fin   <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end

   assign quot = q_r;
   assign rem  = r_r;
endmodule

// File: rtl/lane_sat.sv
// Rounds the quotient up and saturates it to the lane field width.
module lane_sat #(
   parameter int NW     = 26,
   parameter int DW     = 23,
   parameter int LANE_W = 4
) (
   input  logic [NW-1:0]     quot,
   input  logic [DW-1:0]     rem,
   output logic [LANE_W-1:0] lanes
);
   logic [NW:0] up;

   assign up = {1'b0, quot} + (NW+1)'(rem != '0);

   generate
      if (NW + 1 > LANE_W) begin : g_clip
         assign lanes = (|up[NW:LANE_W]) ? {LANE_W{1'b1}} : up[LANE_W-1:0];
      end else begin : g_wide
         assign lanes = LANE_W'(up);
      end
   endgenerate
endmodule

// File: rtl/lane_rules.sv
// Sharing rules between pipes for one lane count.
module lane_rules
   import lane_budget_pkg::*;
#(
   parameter int LANE_W   = 4,
   parameter int MAX_L    = 4,
   parameter int NARROW_L = 2
) (
   input  logic [LANE_W-1:0] lanes,
   input  pipe_id_e          pipe,
   input  plat_mode_e        mode,
   input  logic [LANE_W-1:0] need,
   output logic              accept
);
   localparam logic [LANE_W-1:0] MAX_V = LANE_W'(MAX_L);
   localparam logic [LANE_W-1:0] NAR_V = LANE_W'(NARROW_L);

   always_comb begin
      accept = 1'b0;
      if (lanes > MAX_V) begin
         accept = 1'b0;
      end else if (mode == MODE_NARROW || mode == MODE_NARR2) begin
         accept = (lanes <= NAR_V);
      end else if (mode == MODE_DUAL) begin
         accept = 1'b1;
      end else begin
         case (pipe)
            PIPE_B:  accept = (lanes <= NAR_V) || (need == '0);
            PIPE_C:  accept = (lanes <= NAR_V) && (need <= NAR_V);
            default: accept = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/lane_budget_top.sv
module lane_budget_top
   import lane_budget_pkg::*;
#(
   parameter int PCLK_W    = 20,
   parameter int LR_W      = 20,
   parameter int BPP_W     = 6,
   parameter int LANE_W    = 4,
   parameter int MAX_L     = 4,
   parameter int NARROW_L  = 2,
   parameter int BPP_FLOOR = 18,
   parameter int BPP_STEP  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        pipe_sel,
   input  logic [1:0]        plat_mode,
   input  logic [PCLK_W-1:0] pix_khz,
   input  logic [LR_W-1:0]   link_rate,
   input  logic [BPP_W-1:0]  bpp_in,
   input  logic              peer_en,
   input  logic              peer_ext,
   input  logic [LANE_W-1:0] peer_lanes,
   output logic              done,
   output logic [LANE_W-1:0] lanes,
   output logic [BPP_W-1:0]  bpp_out,
   output logic              ok,
   output logic              fail,
   output logic              constrained
);
   localparam int NW = PCLK_W + BPP_W;
   localparam int DW = LR_W + 3;
   localparam logic [BPP_W-1:0] FLOOR_V = BPP_W'(BPP_FLOOR);
   localparam logic [BPP_W-1:0] STEP_V  = BPP_W'(BPP_STEP);

   generate
      if (LANE_W < 3) begin : g_bad_lane
         $error("LANE_W must hold at least the value 4");
      end
      if (NARROW_L > MAX_L) begin : g_bad_narrow
         $error("NARROW_L may not exceed MAX_L");
      end
      if (BPP_FLOOR >= (1 << BPP_W) || BPP_STEP > BPP_FLOOR) begin : g_bad_bpp
         $error("bpp floor or step does not fit BPP_W");
      end
   endgenerate

   fsm_e              st;
   pipe_id_e          pipe_q;
   plat_mode_e        mode_q;
   logic [PCLK_W-1:0] pix_q;
   logic [LR_W-1:0]   link_q;
   logic [LANE_W-1:0] need_q;
   logic [BPP_W-1:0]  bpp_q;
   logic [LANE_W-1:0] lanes_q;
   logic              cons_q, ok_q, fail_q, done_q;

   logic              div_go, div_fin;
   logic [NW-1:0]     div_num, div_quot;
   logic [DW-1:0]     div_den, div_rem;
   logic [LANE_W-1:0] lanes_new;
   logic              accept;
   logic              busy;

   assign div_go  = (st == ST_KICK);
   assign div_num = NW'(pix_q) * NW'(bpp_q);
   assign div_den = {link_q, 3'b000};
   assign busy    = (st != ST_IDLE);

   lane_div #(.NW(NW), .DW(DW)) u_div (
      .clk (clk), .rst_n(rst_n), .go(div_go),
      .num (div_num), .den(div_den),
      .fin (div_fin), .quot(div_quot), .rem(div_rem)
   );

   lane_sat #(.NW(NW), .DW(DW), .LANE_W(LANE_W)) u_sat (
      .quot(div_quot), .rem(div_rem), .lanes(lanes_new)
   );

   lane_rules #(.LANE_W(LANE_W), .MAX_L(MAX_L), .NARROW_L(NARROW_L)) u_rules (
      .lanes(lanes_q), .pipe(pipe_q), .mode(mode_q),
      .need(need_q), .accept(accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         pipe_q  <= PIPE_A;
         mode_q  <= MODE_DUAL;
         pix_q   <= '0;
         link_q  <= '0;
         need_q  <= '0;
         bpp_q   <= '0;
         lanes_q <= '0;
         cons_q  <= 1'b0;
         ok_q    <= 1'b0;
         fail_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  pipe_q  <= pipe_id_e'(pipe_sel);
                  mode_q  <= plat_mode_e'(plat_mode);
                  pix_q   <= pix_khz;
                  link_q  <= link_rate;
                  need_q  <= (peer_en && peer_ext) ? peer_lanes : '0;
                  bpp_q   <= bpp_in;
                  lanes_q <= '0;
                  cons_q  <= 1'b0;
                  ok_q    <= 1'b0;
                  fail_q  <= 1'b0;
                  st      <= ST_KICK;
               end
            end
            ST_KICK: st <= ST_WAIT;
            ST_WAIT: begin
               if (div_fin) begin
                  lanes_q <= lanes_new;
                  st      <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (accept) begin
                  ok_q   <= 1'b1;
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end else if (bpp_q > FLOOR_V) begin
                  bpp_q  <= bpp_q - STEP_V;
                  cons_q <= 1'b1;
                  st     <= ST_KICK;
               end else begin
                  fail_q <= 1'b1;
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done        = done_q;
   assign lanes       = lanes_q;
   assign bpp_out     = bpp_q;
   assign ok          = ok_q;
   assign fail        = fail_q;
   assign constrained = cons_q;
endmodule

// File: rtl/lane_budget_chk.sv
module lane_budget_chk
   import lane_budget_pkg::*;
#(
   parameter int BPP_W     = 6,
   parameter int LANE_W    = 4,
   parameter int MAX_L     = 4,
   parameter int NARROW_L  = 2,
   parameter int BPP_FLOOR = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input pipe_id_e          pipe_q,
   input plat_mode_e        mode_q,
   input logic              done,
   input logic [LANE_W-1:0] lanes,
   input logic [BPP_W-1:0]  bpp_out,
   input logic              ok,
   input logic              fail
);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ok ^ fail));

   // R2
   lane_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok) |-> (lanes <= LANE_W'(MAX_L)));

   // R9
   fail_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> (bpp_out <= BPP_W'(BPP_FLOOR)));

   // R3
   narrow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok && mode_q[1]) |-> (lanes <= LANE_W'(NARROW_L)));

   // R6
   pipe_c_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok && mode_q == MODE_TRI && pipe_q == PIPE_C) |-> (lanes <= LANE_W'(NARROW_L)));

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(pipe_q) && $stable(mode_q)));
endmodule

bind lane_budget_top lane_budget_chk #(
   .BPP_W(BPP_W), .LANE_W(LANE_W), .MAX_L(MAX_L),
   .NARROW_L(NARROW_L), .BPP_FLOOR(BPP_FLOOR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .pipe_q(pipe_q), .mode_q(mode_q), .done(done), .lanes(lanes),
   .bpp_out(bpp_out), .ok(ok), .fail(fail)
);

// File: tb/tb_lane_budget_top.sv
`timescale 1ns/1ps
module tb_lane_budget_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  pipe_sel = '0;
   logic [1:0]  plat_mode = '0;
   logic [19:0] pix_khz = '0;
   logic [19:0] link_rate = '0;
   logic [5:0]  bpp_in = '0;
   logic        peer_en = 1'b0;
   logic        peer_ext = 1'b0;
   logic [3:0]  peer_lanes = '0;
   logic        done, ok, fail, constrained;
   logic [3:0]  lanes;
   logic [5:0]  bpp_out;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;

   always #2 clk = ~clk;

   lane_budget_top dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pipe_sel(pipe_sel),
      .plat_mode(plat_mode), .pix_khz(pix_khz), .link_rate(link_rate),
      .bpp_in(bpp_in), .peer_en(peer_en), .peer_ext(peer_ext),
      .peer_lanes(peer_lanes), .done(done), .lanes(lanes),
      .bpp_out(bpp_out), .ok(ok), .fail(fail), .constrained(constrained)
   );

   always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

   task automatic chk(input bit good, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model(input int pipe, input int mode, input int pix, input int link,
                        input int b0, input int pen, input int pext, input int plan,
                        output int el, output int eb, output int eok, output int ec,
                        output string tag);
      int need;
      longint num, den, q;
      bit acc;
      need = (pen != 0 && pext != 0) ? plan : 0;
      eb = b0;
      ec = 0;
      forever begin
         num = longint'(pix) * eb;
         den = longint'(link) * 8;
         q = (num + den - 1) / den;
         if (q > 15) q = 15;
         el = int'(q);
         if (el > 4) begin acc = 0; tag = "R2"; end
         else if (mode >= 2) begin acc = (el <= 2); tag = "R3"; end
         else if (mode == 0 || pipe == 0 || pipe == 3) begin acc = 1; tag = "R4"; end
         else if (pipe == 1) begin
            acc = (el <= 2) || (need == 0);
            tag = (el > 2 && need == 0 && plan > 0) ? "R7" : "R5";
         end else begin
            acc = (el <= 2) && (need <= 2);
            tag = (el <= 2 && need <= 2 && plan > 2) ? "R7" : "R6";
         end
         if (acc) begin eok = 1; return; end
         if (eb > 18) begin eb -= 6; ec = 1; end
         else begin eok = 0; return; end
      end
   endtask

   task automatic run(input int pipe, input int mode, input int pix, input int link,
                      input int b0, input int pen, input int pext, input int plan,
                      input bit inject);
      int el, eb, eok, ec, waited, dc0;
      string tag;
      model(pipe, mode, pix, link, b0, pen, pext, plan, el, eb, eok, ec, tag);
      @(negedge clk);
      pipe_sel = 2'(pipe); plat_mode = 2'(mode);
      pix_khz = 20'(pix); link_rate = 20'(link); bpp_in = 6'(b0);
      peer_en = pen[0]; peer_ext = pext[0]; peer_lanes = 4'(plan);
      dc0 = done_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         repeat (4) @(negedge clk);
         pipe_sel = 2'(pipe ^ 1); plat_mode = 2'(mode ^ 1);
         bpp_in = 6'd36; pix_khz = 20'(pix + 200000);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      waited = 0;
      while (!done && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      if (!done) begin
         chk(1'b0, "R10", "watchdog no done", 0, 1);
         return;
      end
      chk(lanes == 4'(el), "R1", "lanes", int'(lanes), el);
      chk(bpp_out == 6'(eb), "R8", "bpp_out", int'(bpp_out), eb);
      chk(constrained == ec[0], "R8", "constrained", int'(constrained), ec);
      chk(ok == eok[0], tag, "ok", int'(ok), eok);
      chk(fail == !eok[0], "R9", "fail", int'(fail), 1 - eok);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
      chk(ok == eok[0], "R10", "ok held", int'(ok), eok);
      if (inject) begin
         repeat (40) @(negedge clk);
         chk(done_cnt == dc0 + 1, "R11", "done count with busy start", done_cnt - dc0, 1);
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL R10 global watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int pixs[6] = '{0, 50000, 148500, 250000, 330000, 400000};
      int pe[5]   = '{0, 1, 1, 1, 1};
      int px[5]   = '{1, 0, 1, 1, 1};
      int pl[5]   = '{3, 3, 0, 2, 3};
      repeat (3) @(negedge clk);
      chk(done == 0 && ok == 0 && fail == 0, "R12", "flags after reset",
          int'({done, ok, fail}), 0);
      chk(constrained == 0 && lanes == 0 && bpp_out == 0, "R12", "values after reset",
          int'({constrained, lanes, bpp_out}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 0 && lanes == 0, "R12", "idle after release", int'(done), 0);

      for (int p = 0; p < 4; p++)
         for (int m = 0; m < 4; m++)
            for (int k = 0; k < 5; k++)
               for (int x = 0; x < 6; x++)
                  for (int b = 0; b < 2; b++) begin
                     if (p == 3 && k > 1) continue;
                     run(p, m, pixs[x], 270000, (b == 0) ? 24 : 36, pe[k], px[k], pl[k], 1'b0);
                  end

      // R8: 20 bpp steps below the floor to 14 and may then fit
      run(1, 1, 330000, 270000, 20, 1, 1, 2, 1'b0);
      // R9: starting at 18 bpp, rejection fails at once
      run(2, 1, 400000, 270000, 18, 0, 0, 0, 1'b0);
      // R2: far too wide even at the floor
      run(0, 0, 1000000, 162000, 36, 0, 0, 0, 1'b0);
      // R1: other link rate
      run(0, 0, 148500, 162000, 24, 0, 0, 0, 1'b0);
      // R11: a start while busy is dropped
      run(1, 1, 330000, 270000, 36, 1, 1, 1, 1'b1);
      run(2, 2, 148500, 270000, 24, 0, 0, 0, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule